// File: doc/BRIEF.md
# Serviced Watchdog on a Periodic Tick

This block is a watchdog that sits after the periodic interrupt tap of a free-running timer chain. Each pulse on its tick input advances a private divide-by-eight stage. When the eighth tick arrives without an intervening service, the block raises a reset request for exactly one clock. The rest of the chip treats that request like any other system reset. The tick already reflects the 2-bit periodic rate select upstream, so the watchdog timeout scales with that rate, and this block needs no knowledge of it.

Software keeps the watchdog quiet by writing a word whose bit 0 is 0 to the service address 0x0FF0 on the bus write port. A service write clears only the watchdog's own divider. The upstream timer stages that generate the tick are outside this block and are never touched. A build-time parameter removes the watchdog function entirely. In that build the request output is held low.

Top module: `svc_watchdog`

## Requirements
- R1: While `rst_n` is low at a rising edge, `rst_req` is 0 after that edge and the tick divider is cleared, so after reset eight fresh ticks are needed before a request.
- R2: With `ENABLE`=1, the eighth tick counted since the last clear makes `rst_req` 1 in the clock cycle that follows the edge sampling that tick.
- R3: Fewer than eight ticks since the last clear never raise `rst_req`, however many idle cycles separate the ticks.
- R4: A service write (`wr_en`=1, `wr_addr`=0x0FF0, `wr_data` bit 0 = 0) clears the divider, so eight further ticks are needed before the next request.
- R5: A write to 0x0FF0 with `wr_data` bit 0 = 1 has no effect on the divider.
- R6: A write with bit 0 = 0 to any address other than 0x0FF0 has no effect on the divider.
- R7: When a service write and the eighth tick occur in the same cycle, the service wins: no request is issued and the divider restarts from zero.
- R8: `rst_req` stays high for one cycle only, and the divider restarts from zero after the request, so the next request needs eight more ticks.
- R9: With `ENABLE`=0, `rst_req` is never asserted, whatever the ticks and writes.
- R10: Data bits other than bit 0 are ignored by the service decode.
- R11: Address and data presented with `wr_en`=0 have no effect on the divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| tick | input | 1 | One-cycle pulse from the selected periodic tap |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W (16) | Bus write address |
| wr_data | input | DATA_W (8) | Bus write data |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
On every cycle, the assertions check several properties against a tick count kept in the checker. A request only follows the eighth counted tick, and that tick always produces one. The request never lasts beyond one cycle. A decoded service write always suppresses the request in the next cycle. The disabled build never raises the request. Some behaviour can only be shown by the bench's scenarios. These are the writes that must be ignored (wrong address, bit 0 set, strobe low), the restart of the count after a service, a reset or a request, and ticks spread out by idle gaps. For each of these, the bench counts the exact number of ticks from a known point and watches the output.

// File: rtl/wdog_pkg.sv
// Package: shared definitions for the serviced watchdog.
// Assumes: included first in compile order.
package wdog_pkg;

    // Default bus geometry and service location
    localparam int          DEF_ADDR_W   = 16;
    localparam int          DEF_DATA_W   = 8;
    localparam logic [15:0] DEF_SVC_ADDR = 16'h0FF0;
    localparam int          DEF_SVC_BIT  = 0;
    localparam int          DEF_DIV      = 8;

    // Action the divider takes in one cycle
    typedef enum logic [1:0] {
        DIV_HOLD  = 2'd0,
        DIV_STEP  = 2'd1,
        DIV_WRAP  = 2'd2,
        DIV_CLEAR = 2'd3
    } div_act_e;

endpackage

// File: rtl/wdog_svc_decode.sv
// Module: wdog_svc_decode
// Recognises a service write: strobe high, address equal to SVC_ADDR
// and the selected data bit equal to 0. The other data bits are ignored.
// Assumes: the write port presents address and data in the strobe cycle.
module wdog_svc_decode #(
    parameter int              ADDR_W   = wdog_pkg::DEF_ADDR_W,
    parameter int              DATA_W   = wdog_pkg::DEF_DATA_W,
    parameter logic [ADDR_W-1:0] SVC_ADDR = ADDR_W'(wdog_pkg::DEF_SVC_ADDR),
    parameter int              SVC_BIT  = wdog_pkg::DEF_SVC_BIT
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              svc_hit
);

    logic addr_match;

    // Compare the write address and key bit against the service location
    always_comb begin
        addr_match = (wr_addr == SVC_ADDR);
        svc_hit    = wr_en && addr_match && !wr_data[SVC_BIT];
    end

endmodule

// File: rtl/wdog_div_stage.sv
// Module: wdog_div_stage
// Counts tick pulses modulo DIV. It flags 'fire' on the tick that
// completes the count. A clear request resets the count and overrides a
// coinciding tick, so no fire is raised in that cycle.
// Assumes: tick is a single-cycle pulse; rst_n is synchronous, active low.
module wdog_div_stage #(
    parameter int DIV = wdog_pkg::DEF_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    output logic fire
);
    import wdog_pkg::*;

    localparam int                 CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0]   LAST  = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    div_act_e         act;

    // Pick this cycle's action: a clear beats a tick
    always_comb begin
        if (clear)                act = DIV_CLEAR;
        else if (!tick)           act = DIV_HOLD;
        else if (cnt_q == LAST)   act = DIV_WRAP;
        else                      act = DIV_STEP;
        fire = (act == DIV_WRAP);
    end

    // Update the tick count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case (act)
                DIV_STEP:             cnt_q <= cnt_q + 1'b1;
                DIV_WRAP, DIV_CLEAR:  cnt_q <= '0;
                default:              cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/wdog_req_gen.sv
// Module: wdog_req_gen
// Registers the fire event into a one-cycle reset request.
// Assumes: fire is high for at most one cycle per count period.
module wdog_req_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic req
);

    // Hold the request for the single cycle after a fire
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= fire;
    end

endmodule

// File: rtl/svc_watchdog.sv
// Module: svc_watchdog (top)
// Watchdog after a periodic tick. After DIV ticks with no service write,
// it issues a one-cycle reset request. A service write clears only this
// block's divider. ENABLE=0 builds no watchdog and holds the request low.
// Assumes: tick comes from the already rate-selected periodic tap.
module svc_watchdog #(
    parameter int                ENABLE   = 1,
    parameter int                ADDR_W   = wdog_pkg::DEF_ADDR_W,
    parameter int                DATA_W   = wdog_pkg::DEF_DATA_W,
    parameter logic [ADDR_W-1:0] SVC_ADDR = ADDR_W'(wdog_pkg::DEF_SVC_ADDR),
    parameter int                SVC_BIT  = wdog_pkg::DEF_SVC_BIT,
    parameter int                DIV      = wdog_pkg::DEF_DIV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rst_req
);

    generate
        if (ENABLE != 0) begin : g_on
            logic svc_hit;
            logic fire;

            wdog_svc_decode #(
                .ADDR_W   (ADDR_W),
                .DATA_W   (DATA_W),
                .SVC_ADDR (SVC_ADDR),
                .SVC_BIT  (SVC_BIT)
            ) u_decode (
                .wr_en    (wr_en),
                .wr_addr  (wr_addr),
                .wr_data  (wr_data),
                .svc_hit  (svc_hit)
            );

            wdog_div_stage #(
                .DIV   (DIV)
            ) u_div (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .clear (svc_hit),
                .fire  (fire)
            );

            wdog_req_gen u_req (
                .clk   (clk),
                .rst_n (rst_n),
                .fire  (fire),
                .req   (rst_req)
            );
        end else begin : g_off
            // Watchdog not built: request held inactive
            assign rst_req = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/svc_watchdog_chk.sv
// Module: svc_watchdog_chk
// Checker bound to svc_watchdog. It keeps its own count of ticks since
// the last clear and checks the request against that count.
module svc_watchdog_chk #(
    parameter int                ENABLE   = 1,
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = '0,
    parameter int                SVC_BIT  = 0,
    parameter int                DIV      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rst_req
);
    localparam int M_W = $clog2(DIV + 1);
    localparam logic [M_W-1:0] M_LAST = M_W'(DIV - 1);

    logic           svc;
    logic [M_W-1:0] m_cnt;

    // Service write as seen at the ports
    assign svc = wr_en && (wr_addr == SVC_ADDR) && !wr_data[SVC_BIT];

    // Ticks seen since reset, service or wrap
    always_ff @(posedge clk) begin
        if (!rst_n)                      m_cnt <= '0;
        else if (svc)                    m_cnt <= '0;
        else if (tick && m_cnt == M_LAST) m_cnt <= '0;
        else if (tick)                   m_cnt <= m_cnt + 1'b1;
    end

    // R1: reset leaves no request behind
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !rst_req);

    // R2: the completing tick always yields a request
    assert_fire_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ENABLE != 0 && tick && !svc && m_cnt == M_LAST) |=> rst_req);

    // R3: a request only follows the completing tick
    assert_no_early_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(tick) && $past(m_cnt) == M_LAST && !$past(svc)));

    // R7: a service write suppresses the next-cycle request
    assert_service_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> !rst_req);

    // R8: request is a single-cycle pulse
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9: the disabled build stays silent
    always_comb begin
        if (ENABLE == 0) assert_off_silent_R9: assert (rst_req !== 1'b1);
    end

endmodule

bind svc_watchdog svc_watchdog_chk #(
    .ENABLE   (ENABLE),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SVC_ADDR (SVC_ADDR),
    .SVC_BIT  (SVC_BIT),
    .DIV      (DIV)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rst_req (rst_req)
);

// File: tb/svc_watchdog_bench.sv
module svc_watchdog_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rst_req;
    logic        off_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    svc_watchdog u_svc_watchdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rst_req(rst_req)
    );

    svc_watchdog #(.ENABLE(0)) u_svc_watchdog_off (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rst_req(off_req)
    );

    // Segment: {pre_ticks[34:31], act[30:29], addr[28:13], data[12:5], exp[4], req[3:0]}
    // act: 0 idle, 1 tick, 2 write, 3 tick+write
    localparam int NSEG = 12;
    localparam logic [34:0] SEGS [NSEG] = '{
        {4'd7, 2'd1, 16'h0000, 8'h00, 1'b1, 4'd2},   // R2 eighth tick fires
        {4'd0, 2'd0, 16'h0000, 8'h00, 1'b0, 4'd8},   // R8 pulse ends
        {4'd5, 2'd2, 16'h0FF0, 8'h00, 1'b0, 4'd4},   // R4 service
        {4'd7, 2'd1, 16'h0000, 8'h00, 1'b1, 4'd4},   // R4 eight fresh ticks
        {4'd7, 2'd2, 16'h0FF0, 8'h01, 1'b0, 4'd5},   // R5 bit0 set
        {4'd0, 2'd1, 16'h0000, 8'h00, 1'b1, 4'd5},   // R5 count kept
        {4'd7, 2'd2, 16'h0FF1, 8'h00, 1'b0, 4'd6},   // R6 wrong address
        {4'd0, 2'd1, 16'h0000, 8'h00, 1'b1, 4'd6},   // R6 count kept
        {4'd7, 2'd3, 16'h0FF0, 8'hFE, 1'b0, 4'd7},   // R7 service beats tick
        {4'd7, 2'd1, 16'h0000, 8'h00, 1'b1, 4'd7},   // R7 restart from zero
        {4'd3, 2'd2, 16'h0FF0, 8'hAA, 1'b0, 4'd10},  // R10 high bits ignored
        {4'd7, 2'd1, 16'h0000, 8'h00, 1'b1, 4'd10}   // R10 service took effect
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rst_req=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus at a falling edge; return at the next one
    task automatic step(input logic t, input logic w, input logic [15:0] a, input logic [7:0] d);
        tick = t; wr_en = w; wr_addr = a; wr_data = d;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic quiet_ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, 16'h0, 8'h0);
            check(tag, rst_req, 1'b0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, rst_req=%b expected completion", rst_req);
        finish_run();
    end

    // R9: disabled build watched on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) check("R9 disabled", off_req, 1'b0);
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", rst_req, 1'b0);
        rst_n = 1'b1;

        // Table walk
        for (int s = 0; s < NSEG; s++) begin
            logic [3:0]  pre  = SEGS[s][34:31];
            logic [1:0]  act  = SEGS[s][30:29];
            logic [15:0] addr = SEGS[s][28:13];
            logic [7:0]  dat  = SEGS[s][12:5];
            logic        exp  = SEGS[s][4];
            quiet_ticks(int'(pre), "R3 early tick");
            step(act[0], act[1], addr, dat);
            check($sformatf("R%0d seg %0d", SEGS[s][3:0], s), rst_req, exp);
        end

        // R1: reset mid-count clears the divider
        quiet_ticks(5, "R3 pre-reset");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset", rst_req, 1'b0);
        rst_n = 1'b1;
        quiet_ticks(7, "R1 count cleared");
        step(1'b1, 1'b0, 16'h0, 8'h0);
        check("R1 eighth after reset", rst_req, 1'b1);

        // R3: ticks spread by idle gaps still count, none early
        for (int i = 0; i < 7; i++) begin
            step(1'b1, 1'b0, 16'h0, 8'h0);
            check("R3 gapped tick", rst_req, 1'b0);
            repeat (3) begin
                step(1'b0, 1'b0, 16'h0, 8'h0);
                check("R3 gap idle", rst_req, 1'b0);
            end
        end
        step(1'b1, 1'b0, 16'h0, 8'h0);
        check("R3 gapped eighth", rst_req, 1'b1);

        // R11: service pattern without strobe is ignored
        quiet_ticks(7, "R3 pre-R11");
        tick = 1'b0; wr_en = 1'b0; wr_addr = 16'h0FF0; wr_data = 8'h00;
        @(negedge clk);
        check("R11 no strobe", rst_req, 1'b0);
        step(1'b1, 1'b0, 16'h0, 8'h0);
        check("R11 count kept", rst_req, 1'b1);

        // R8: pulse is one cycle, then eight more ticks needed
        step(1'b0, 1'b0, 16'h0, 8'h0);
        check("R8 pulse width", rst_req, 1'b0);
        quiet_ticks(7, "R8 restart");
        step(1'b1, 1'b0, 16'h0, 8'h0);
        check("R8 second request", rst_req, 1'b1);

        @(negedge clk);
        finish_run();
    end

endmodule